// File: doc/BRIEF.md
# Chained Descriptor DMA Channel Engine

This block moves data for a single DMA channel. Once started, it reads a four-word descriptor from memory. The descriptor gives the link to the next descriptor, the source and target addresses, and a command word. The engine then copies the programmed number of bytes in bursts. For each burst it first reads every element into a local byte buffer and then writes them all out. When a descriptor is used up, it either loads the next descriptor of the chain or terminates the channel. The channel can also start directly from register values supplied on its inputs, without any descriptor fetch.

All memory traffic goes through one 32-bit master port with a valid/ready request handshake and a separate response strobe. The engine holds `mem_req_valid_o` and every request field steady until `mem_req_ready_i` is seen high at a clock edge. It issues nothing more until `mem_rsp_valid_i` returns for that access, so at most one access is ever outstanding and a slow memory simply stretches each access. Flow-controlled descriptors pace bursts on a peripheral request level. When that level falls at the end of a burst, the engine reports end-of-receive and pauses, stops, or jumps to the next descriptor. Events leave as one-cycle strobes to the channel status logic.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset `run_o` is 0, no memory request is made and all event strobes are low; a `start_i` pulse while idle sets `run_o`.
- R2: In fetch mode the descriptor is read as four consecutive words starting at the pointer with its low 4 bits cleared; the words are, in order, next-pointer, source, target, command.
- R3: When pointer bit 1 is set and `cmp_flag_i` is high, the descriptor is fetched from 32 bytes above the cleared pointer.
- R4: When the remaining length is zero, a clear next-pointer bit 0 with `no_fetch_i` and `stop_on_eor_i` low makes the engine fetch the next descriptor. Otherwise it pulses `ev_stop_o` and clears `run_o`.
- R5: Command bits 15:14 select the element width (1→1 byte, 2→2 bytes, 3→4 bytes, 0 treated as 4 bytes). Bits 17:16 select the burst as 4 shifted left by the code. Each burst reads min(remaining, burst) bytes and only then writes them.
- R6: Command bit 31 advances the source address by the width after each read, and bit 30 does the same for the target after each write; a clear bit keeps that address fixed.
- R7: With command bit 29 (source paced) or bit 28 (target paced) set, no burst begins while `req_i` is low, and the paced address has its low 2 bits cleared when the descriptor is loaded.
- R8: Command bit 22 pulses `ev_start_o` when a descriptor is loaded. Bit 21 pulses `ev_end_o` when the length reaches zero.
- R9: If `req_i` is low after a paced burst, `ev_eor_o` pulses. The engine then stops (`ev_stop_o`, run cleared) if `stop_on_eor_i` is set. Otherwise it fetches the next descriptor if `jump_on_eor_i` is set and fetching is enabled, and otherwise it waits for `req_i`.
- R10: `cmd_o[12:0]` holds the remaining byte count, updated after every burst.
- R11: A request stays valid with a stable address until accepted, and only one access is outstanding. Write data sits on byte lanes starting at address bits 1:0, with one strobe per byte.
- R12: A start with `no_fetch_i` high takes source, target and command from `src_i`, `trg_i`, `cmd_i`, performs no descriptor read, and clears `run_o` when the length reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| desc_ptr_i | input | 32 | First descriptor pointer |
| no_fetch_i | input | 1 | Run from direct inputs, never fetch descriptors |
| stop_on_eor_i | input | 1 | Stop on end-of-receive |
| jump_on_eor_i | input | 1 | Fetch next descriptor on end-of-receive |
| cmp_flag_i | input | 1 | Compare status used for branch fetch |
| src_i | input | 32 | Direct source address |
| trg_i | input | 32 | Direct target address |
| cmd_i | input | 32 | Direct command word |
| req_i | input | 1 | Peripheral request level |
| run_o | output | 1 | Channel running |
| cmd_o | output | 32 | Current command word with remaining length |
| ev_start_o | output | 1 | Descriptor-loaded event strobe |
| ev_end_o | output | 1 | Length-exhausted event strobe |
| ev_stop_o | output | 1 | Channel-stopped event strobe |
| ev_eor_o | output | 1 | End-of-receive event strobe |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Byte address |
| mem_req_wdata_o | output | 32 | Write data on byte lanes |
| mem_req_strb_o | output | 4 | Byte strobes for writes |
| mem_rsp_valid_i | input | 1 | Response for the outstanding access |
| mem_rsp_rdata_i | input | 32 | Read data word |

## Verification
If a descriptor register is loaded wrongly, the fault first shows up in the address of the next data request. Within one burst it also shows up as misplaced bytes in target memory. A wrong burst offset or byte-lane choice corrupts target bytes or strobes on the very next write. A wrong remaining length shows in `cmd_o` at the end of that burst, and it shows as a missing or extra `ev_end_o` and `ev_stop_o` when the chain ends. Errors in the pacing logic show as memory requests while `req_i` is low, or as an absent `ev_eor_o` one cycle after the burst completes.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 13;
  localparam int unsigned BURST_MAX = 32;
  localparam int unsigned IDX_W     = $clog2(BURST_MAX);
  localparam int unsigned BCNT_W    = IDX_W + 1;
  localparam int unsigned LANES     = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_RD, ST_WR, ST_POST
  } eng_state_e;

  function automatic logic [WORD_W-1:0] desc_fetch_addr(input logic [WORD_W-1:0] ptr,
                                                        input logic cmp);
    logic [WORD_W-1:0] base;
    base = {ptr[WORD_W-1:4], 4'h0};
    return (ptr[1] && cmp) ? base + WORD_W'(32) : base;
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chain_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [2:0]        width_o,
  output logic [BCNT_W-1:0] burst_o,
  output logic              inc_src_o,
  output logic              inc_trg_o,
  output logic              pace_o,
  output logic              pace_src_o,
  output logic              pace_trg_o,
  output logic              start_ie_o,
  output logic              end_ie_o
);
  always_comb begin
    len_o      = cmd_i[LEN_W-1:0];
    unique case (cmd_i[15:14])
      2'd1:    width_o = 3'd1;
      2'd2:    width_o = 3'd2;
      default: width_o = 3'd4;
    endcase
    burst_o    = BCNT_W'(4) << cmd_i[17:16];
    inc_src_o  = cmd_i[31];
    inc_trg_o  = cmd_i[30];
    pace_src_o = cmd_i[29];
    pace_trg_o = cmd_i[28];
    pace_o     = cmd_i[29] | cmd_i[28];
    start_ie_o = cmd_i[22];
    end_ie_o   = cmd_i[21];
  end

  always_comb begin
    AST_WIDTH_ONEHOT: assert ($countones(width_o) == 1); // R5
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [BCNT_W-1:0] wr_idx_i,
  input  logic [1:0]        wr_lane_i,
  input  logic [2:0]        wr_cnt_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [BCNT_W-1:0] rd_idx_i,
  input  logic [1:0]        rd_lane_i,
  input  logic [2:0]        rd_cnt_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [LANES-1:0]  rd_strb_o
);
  logic [7:0] bytes_q [BURST_MAX];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(wr_cnt_i))
          bytes_q[IDX_W'(int'(wr_idx_i) + j)] <= wr_word_i[8*int'(2'(wr_lane_i + 2'(j))) +: 8];
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    rd_strb_o = '0;
    for (int j = 0; j < LANES; j++) begin
      if (j < int'(rd_cnt_i)) begin
        rd_word_o[8*int'(2'(rd_lane_i + 2'(j))) +: 8] = bytes_q[IDX_W'(int'(rd_idx_i) + j)];
        rd_strb_o[2'(rd_lane_i + 2'(j))] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] desc_ptr_i,
  input  logic              no_fetch_i,
  input  logic              stop_on_eor_i,
  input  logic              jump_on_eor_i,
  input  logic              cmp_flag_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] trg_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic              req_i,
  output logic              run_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              ev_start_o,
  output logic              ev_end_o,
  output logic              ev_stop_o,
  output logic              ev_eor_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [WORD_W-1:0] mem_req_addr_o,
  output logic [WORD_W-1:0] mem_req_wdata_o,
  output logic [LANES-1:0]  mem_req_strb_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_rdata_i
);
  eng_state_e        st_q;
  logic              run_q, busy_q;
  logic [WORD_W-1:0] desc_q, src_q, trg_q, cmd_q, fbase_q;
  logic [1:0]        fidx_q;
  logic [BCNT_W-1:0] boff_q, bsize_q;
  logic              ev_start_q, ev_end_q, ev_stop_q, ev_eor_q;

  logic [LEN_W-1:0]  len;
  logic [2:0]        width;
  logic [BCNT_W-1:0] burst;
  logic              inc_src, inc_trg, pace, pace_src, pace_trg, start_ie, end_ie;

  dma_cmd_decode u_dec (
    .cmd_i      (cmd_q),
    .len_o      (len),
    .width_o    (width),
    .burst_o    (burst),
    .inc_src_o  (inc_src),
    .inc_trg_o  (inc_trg),
    .pace_o     (pace),
    .pace_src_o (pace_src),
    .pace_trg_o (pace_trg),
    .start_ie_o (start_ie),
    .end_ie_o   (end_ie)
  );

  logic              accept, done;
  logic [1:0]        lane_mask;
  logic [BCNT_W-1:0] width_ext, bsize_next;
  logic              burst_last, eor_now, term_zero;
  logic [LEN_W-1:0]  len_after;
  logic [WORD_W-1:0] buf_word;
  logic [LANES-1:0]  buf_strb;

  assign accept     = mem_req_valid_o && mem_req_ready_i;
  assign done       = busy_q && mem_rsp_valid_i;
  assign lane_mask  = ~(width[1:0] - 2'd1);
  assign width_ext  = BCNT_W'(width);
  assign bsize_next = (len < LEN_W'(burst)) ? BCNT_W'(len) : burst;
  assign burst_last = ({1'b0, boff_q} + {1'b0, width_ext}) >= {1'b0, bsize_q};
  assign len_after  = len - LEN_W'(bsize_q);
  assign eor_now    = pace && !req_i;
  assign term_zero  = no_fetch_i || desc_q[0] || stop_on_eor_i;

  dma_burst_buf u_buf (
    .clk       (clk),
    .wr_en_i   ((st_q == ST_RD) && done),
    .wr_idx_i  (boff_q),
    .wr_lane_i (src_q[1:0] & lane_mask),
    .wr_cnt_i  (width),
    .wr_word_i (mem_rsp_rdata_i),
    .rd_idx_i  (boff_q),
    .rd_lane_i (trg_q[1:0] & lane_mask),
    .rd_cnt_i  (width),
    .rd_word_o (buf_word),
    .rd_strb_o (buf_strb)
  );

  always_comb begin
    mem_req_valid_o = !busy_q && (st_q == ST_FETCH || st_q == ST_RD || st_q == ST_WR);
    mem_req_we_o    = (st_q == ST_WR);
    mem_req_wdata_o = (st_q == ST_WR) ? buf_word : '0;
    mem_req_strb_o  = (st_q == ST_WR) ? buf_strb : '0;
    unique case (st_q)
      ST_FETCH: mem_req_addr_o = fbase_q + {{(WORD_W-4){1'b0}}, fidx_q, 2'b00};
      ST_RD:    mem_req_addr_o = src_q;
      ST_WR:    mem_req_addr_o = trg_q;
      default:  mem_req_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  run_q <= 1'b0;  busy_q <= 1'b0;
      desc_q <= '0;  src_q <= '0;  trg_q <= '0;  cmd_q <= '0;  fbase_q <= '0;
      fidx_q <= '0;  boff_q <= '0;  bsize_q <= '0;
      ev_start_q <= 1'b0;  ev_end_q <= 1'b0;  ev_stop_q <= 1'b0;  ev_eor_q <= 1'b0;
    end else begin
      ev_start_q <= 1'b0;  ev_end_q <= 1'b0;  ev_stop_q <= 1'b0;  ev_eor_q <= 1'b0;
      if (accept) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          run_q <= 1'b1;
          if (no_fetch_i) begin
            src_q <= src_i;  trg_q <= trg_i;  cmd_q <= cmd_i;
            st_q  <= ST_WAIT;
          end else begin
            desc_q  <= desc_ptr_i;
            fbase_q <= desc_fetch_addr(desc_ptr_i, cmp_flag_i);
            fidx_q  <= '0;
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: if (done) begin
          fidx_q <= fidx_q + 2'd1;
          unique case (fidx_q)
            2'd0: desc_q <= mem_rsp_rdata_i;
            2'd1: src_q  <= mem_rsp_rdata_i;
            2'd2: trg_q  <= mem_rsp_rdata_i;
            default: begin
              cmd_q <= mem_rsp_rdata_i;
              if (mem_rsp_rdata_i[29]) src_q[1:0] <= 2'b00;
              if (mem_rsp_rdata_i[28]) trg_q[1:0] <= 2'b00;
              ev_start_q <= mem_rsp_rdata_i[22];
              st_q <= ST_WAIT;
            end
          endcase
        end
        ST_WAIT: if (!eor_now) begin
          if (len == '0) st_q <= ST_POST;
          else begin
            bsize_q <= bsize_next;
            boff_q  <= '0;
            st_q    <= ST_RD;
          end
        end
        ST_RD: if (done) begin
          if (inc_src) src_q <= src_q + WORD_W'(width);
          if (burst_last) begin
            boff_q <= '0;
            st_q   <= ST_WR;
          end else boff_q <= boff_q + width_ext;
        end
        ST_WR: if (done) begin
          if (inc_trg) trg_q <= trg_q + WORD_W'(width);
          if (burst_last) begin
            cmd_q[LEN_W-1:0] <= len_after;
            st_q <= ST_POST;
          end else boff_q <= boff_q + width_ext;
        end
        ST_POST: begin
          ev_eor_q <= eor_now;
          if (len == '0) begin
            ev_end_q <= end_ie;
            if (term_zero) begin
              ev_stop_q <= 1'b1;  run_q <= 1'b0;  st_q <= ST_IDLE;
            end else begin
              fbase_q <= desc_fetch_addr(desc_q, cmp_flag_i);
              fidx_q  <= '0;
              st_q    <= ST_FETCH;
            end
          end else if (eor_now) begin
            if (stop_on_eor_i) begin
              ev_stop_q <= 1'b1;  run_q <= 1'b0;  st_q <= ST_IDLE;
            end else if (jump_on_eor_i && !no_fetch_i) begin
              fbase_q <= desc_fetch_addr(desc_q, cmp_flag_i);
              fidx_q  <= '0;
              st_q    <= ST_FETCH;
            end else st_q <= ST_WAIT;
          end else st_q <= ST_WAIT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o      = run_q;
  assign cmd_o      = cmd_q;
  assign ev_start_o = ev_start_q;
  assign ev_end_o   = ev_end_q;
  assign ev_stop_o  = ev_stop_q;
  assign ev_eor_o   = ev_eor_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R11
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !mem_req_valid_o); // R1
  AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_o |-> !run_o); // R4
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_o |-> cmd_o[LEN_W-1:0] == '0); // R8
  AST_WR_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_we_o |-> $countones(mem_req_strb_o) == int'(width)); // R5
  AST_PACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && pace && !req_i) |=> !mem_req_valid_o); // R7
endmodule

// File: tb/dma_chain_engine_bench.sv
module dma_chain_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start_i = 0, no_fetch_i = 0, stop_on_eor_i = 0, jump_on_eor_i = 0;
  logic        cmp_flag_i = 0, req_i = 0;
  logic [31:0] desc_ptr_i = 0, src_i = 0, trg_i = 0, cmd_i = 0;
  logic        run_o, ev_start_o, ev_end_o, ev_stop_o, ev_eor_o;
  logic [31:0] cmd_o;
  logic        mem_req_valid_o, mem_req_we_o;
  logic        rdy = 1'b1, rsp_v = 1'b0;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o, rdata = 0;
  logic [3:0]  mem_req_strb_o;

  dma_chain_engine u_dma_chain_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
    .no_fetch_i(no_fetch_i), .stop_on_eor_i(stop_on_eor_i), .jump_on_eor_i(jump_on_eor_i),
    .cmp_flag_i(cmp_flag_i), .src_i(src_i), .trg_i(trg_i), .cmd_i(cmd_i), .req_i(req_i),
    .run_o(run_o), .cmd_o(cmd_o), .ev_start_o(ev_start_o), .ev_end_o(ev_end_o),
    .ev_stop_o(ev_stop_o), .ev_eor_o(ev_eor_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(rdy), .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_req_strb_o(mem_req_strb_o),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_rdata_i(rdata)
  );

  logic [7:0] mem_b [1024];
  logic [7:0] exp_b [1024];
  int cyc = 0, checks = 0, fails = 0;
  int n_start = 0, n_end = 0, n_stop = 0, n_eor = 0, n_desc_rd = 0, hs_viol = 0;
  logic       prev_hold = 0;
  logic [31:0] prev_addr = 0;
  logic [9:0] ma;

  // memory model: accepts when ready, answers one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rsp_v <= 1'b0;
      rdy   <= 1'b1;
    end else begin
      rsp_v <= 1'b0;
      rdy   <= (cyc % 5) != 3;
      if (mem_req_valid_o && rdy) begin
        rsp_v <= 1'b1;
        ma = {mem_req_addr_o[9:2], 2'b00};
        if (mem_req_we_o) begin
          for (int j = 0; j < 4; j++)
            if (mem_req_strb_o[j]) mem_b[ma + 10'(j)] <= mem_req_wdata_o[8*j +: 8];
        end else
          rdata <= {mem_b[ma + 10'd3], mem_b[ma + 10'd2], mem_b[ma + 10'd1], mem_b[ma]};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_start_o) n_start++;
      if (ev_end_o)   n_end++;
      if (ev_stop_o)  n_stop++;
      if (ev_eor_o)   n_eor++;
      if (mem_req_valid_o && rdy && !mem_req_we_o && mem_req_addr_o < 32'h100) n_desc_rd++;
      if (prev_hold && (!mem_req_valid_o || mem_req_addr_o != prev_addr)) hs_viol++;
      prev_hold = mem_req_valid_o && !rdy;
      prev_addr = mem_req_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem_b[a + i] = v[8*i +: 8];
  endtask

  function automatic logic [31:0] mk_cmd(input logic [1:0] wc, input logic [1:0] bc,
      input logic [12:0] len, input logic is, input logic it, input logic ps,
      input logic sie, input logic eie);
    return {is, it, ps, 1'b0, 5'b0, sie, eie, 3'b0, bc, wc, 1'b0, len};
  endfunction

  function automatic int wbytes(input logic [1:0] wc);
    return (wc == 2'd1) ? 1 : (wc == 2'd2) ? 2 : 4;
  endfunction

  task automatic clear_dst();
    for (int i = 'h200; i < 'h300; i++) begin mem_b[i] = 8'h00; exp_b[i] = 8'h00; end
  endtask

  task automatic model(input int src, input int dst, input int len, input int w,
                       input bit is, input bit it);
    for (int k = 0; k < len / w; k++)
      for (int j = 0; j < w; j++)
        exp_b[dst + (it ? k*w : 0) + j] = mem_b[src + (is ? k*w : 0) + j];
  endtask

  task automatic cmp_dst(input string req);
    int bad = 0;
    for (int i = 'h200; i < 'h300; i++) if (mem_b[i] !== exp_b[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic clr_counts();
    n_start = 0; n_end = 0; n_stop = 0; n_eor = 0; n_desc_rd = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && run_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // row: [20:19] width code, [18:17] burst code, [16:4] length, [3] inc src, [2] inc trg, [1] start ie, [0] end ie
  localparam logic [20:0] VEC [7] = '{
    {2'd3, 2'd1, 13'd16, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd1, 2'd0, 13'd7,  1'b1, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'd2, 13'd20, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd3, 2'd3, 13'd64, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd3, 2'd1, 13'd12, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'd1, 13'd5,  1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 13'd8,  1'b1, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    for (int i = 0; i < 1024; i++) begin mem_b[i] = 8'h00; exp_b[i] = 8'h00; end
    for (int i = 'h100; i < 'h200; i++) mem_b[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(run_o == 0 && !mem_req_valid_o, "R1 reset idle", {run_o, mem_req_valid_o}, 0);
    chk({ev_start_o, ev_end_o, ev_stop_o, ev_eor_o} == 0, "R1 reset events",
        {ev_start_o, ev_end_o, ev_stop_o, ev_eor_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table of single-descriptor transfers: R2 R4 R5 R6 R8 R10
    for (int r = 0; r < 7; r++) begin
      logic [20:0] v = VEC[r];
      clear_dst(); clr_counts();
      put_word('h000, 32'h1);
      put_word('h004, 32'h100);
      put_word('h008, 32'h200);
      put_word('h00C, mk_cmd(v[20:19], v[18:17], v[16:4], v[3], v[2], 1'b0, v[1], v[0]));
      model('h100, 'h200, int'(v[16:4]), wbytes(v[20:19]), v[3], v[2]);
      desc_ptr_i = 32'h0;
      pulse_start();
      chk(run_o == 1, "R1 start sets run", run_o, 1);
      wait_idle();
      cmp_dst("R5 R6 table copy");
      chk(n_start == int'(v[1]), "R8 start event", n_start, v[1]);
      chk(n_end == int'(v[0]), "R8 end event", n_end, v[0]);
      chk(n_stop == 1 && run_o == 0, "R4 stop at last descriptor", n_stop, 1);
      chk(cmd_o[12:0] == 0, "R10 length zero", cmd_o[12:0], 0);
    end

    // chain of two descriptors: R2 R4
    clear_dst(); clr_counts();
    put_word('h000, 32'h40);  put_word('h004, 32'h100); put_word('h008, 32'h200);
    put_word('h00C, mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 0, 1, 0));
    put_word('h040, 32'h1);   put_word('h044, 32'h110); put_word('h048, 32'h210);
    put_word('h04C, mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 0, 1, 0));
    model('h100, 'h200, 8, 4, 1, 1); model('h110, 'h210, 8, 4, 1, 1);
    desc_ptr_i = 32'h0;
    pulse_start(); wait_idle();
    cmp_dst("R4 chain copy");
    chk(n_start == 2, "R4 chain loads two", n_start, 2);
    chk(n_stop == 1, "R4 chain single stop", n_stop, 1);

    // branch fetch: R3
    clear_dst(); clr_counts();
    put_word('h080, 32'h1); put_word('h084, 32'h100); put_word('h088, 32'h240);
    put_word('h08C, mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 0, 0, 0));
    put_word('h0A0, 32'h1); put_word('h0A4, 32'h120); put_word('h0A8, 32'h260);
    put_word('h0AC, mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 0, 0, 0));
    model('h120, 'h260, 8, 4, 1, 1);
    desc_ptr_i = 32'h082; cmp_flag_i = 1;
    pulse_start(); wait_idle();
    cmp_flag_i = 0;
    cmp_dst("R3 branch target only");

    // pacing: R7
    clear_dst(); clr_counts();
    put_word('h000, 32'h1); put_word('h004, 32'h103); put_word('h008, 32'h200);
    put_word('h00C, mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 1, 0, 0));
    model('h100, 'h200, 8, 4, 1, 1);
    desc_ptr_i = 32'h0; req_i = 0;
    pulse_start();
    repeat (40) @(negedge clk);
    chk(run_o == 1 && !mem_req_valid_o, "R7 waits for request", {run_o, mem_req_valid_o}, 2);
    chk(mem_b['h200] == 8'h00, "R7 no data moved", mem_b['h200], 0);
    req_i = 1;
    wait_idle();
    cmp_dst("R7 aligned paced copy");

    // end-of-receive with stop: R9 R10
    clear_dst(); clr_counts();
    put_word('h00C, mk_cmd(2'd3, 2'd1, 13'd32, 1, 1, 1, 0, 1));
    stop_on_eor_i = 1; req_i = 1;
    pulse_start();
    for (int i = 0; i < 2000 && !(mem_req_valid_o && mem_req_we_o && rdy); i++) @(negedge clk);
    req_i = 0;
    wait_idle();
    chk(n_eor == 1, "R9 eor event", n_eor, 1);
    chk(n_stop == 1 && run_o == 0, "R9 stop on eor", run_o, 0);
    chk(cmd_o[12:0] == 13'd24, "R10 remaining after eor", cmd_o[12:0], 24);
    chk(n_end == 0, "R8 no end before zero", n_end, 0);
    stop_on_eor_i = 0;

    // end-of-receive pause then resume: R9
    clear_dst(); clr_counts();
    model('h100, 'h200, 32, 4, 1, 1);
    req_i = 1;
    pulse_start();
    for (int i = 0; i < 2000 && !(mem_req_valid_o && mem_req_we_o && rdy); i++) @(negedge clk);
    req_i = 0;
    for (int i = 0; i < 2000 && n_eor == 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(run_o == 1 && cmd_o[12:0] == 13'd24, "R9 paused after eor", cmd_o[12:0], 24);
    chk(!mem_req_valid_o, "R9 no traffic while paused", mem_req_valid_o, 0);
    req_i = 1;
    wait_idle();
    cmp_dst("R9 resumed copy");
    chk(n_end == 1 && n_stop == 1, "R9 finish after resume", n_end, 1);

    // direct start without descriptor: R12
    clear_dst(); clr_counts();
    model('h120, 'h220, 8, 4, 1, 1);
    no_fetch_i = 1; src_i = 32'h120; trg_i = 32'h220;
    cmd_i = mk_cmd(2'd3, 2'd1, 13'd8, 1, 1, 0, 0, 1);
    pulse_start(); wait_idle();
    no_fetch_i = 0;
    cmp_dst("R12 direct copy");
    chk(n_desc_rd == 0, "R12 no descriptor read", n_desc_rd, 0);
    chk(run_o == 0 && n_end == 1, "R12 run cleared", run_o, 0);

    chk(hs_viol == 0, "R11 request held until accepted", hs_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule